// File: doc/BRIEF.md
# Multi-Cycle Accumulator Controller

This block is a small accumulator machine whose control is a Moore state machine. Each instruction is one byte. The upper two bits hold the opcode and the lower six bits hold a data-memory address. The three operations are load into the accumulator, store the accumulator, and add a memory word to the accumulator. The machine fetches an instruction from its instruction memory, decodes it in an operand cycle, and then runs one or two execute cycles before it fetches again. The number of cycles depends on the operation. The fourth opcode value is illegal and parks the machine in a trap state that only reset can leave.

Both memories are filled through one write-only stream port. A word moves when `ld_valid` and `ld_ready` are both high at a rising clock edge. While `ld_valid` is high, the source keeps `ld_target`, `ld_addr` and `ld_data` steady until that transfer. The block pulls `ld_ready` low only in the cycle in which the machine itself writes data memory, so the port never competes with a store. The port stays usable during reset and while trapped. The control strobes, the state code, the accumulator and the program counter are plain outputs.

Top module: `acc_mc_core`

## Requirements
- R1: Instruction bits [7:6] are the opcode and bits [5:0] the data address. Opcode 00 is load, 01 is store, 10 is add and 11 is illegal.
- R2: `state_o` uses these codes: fetch 000, operand 001, load-acc 011, write-acc 010, exec-add 100, write-mem 101 and trap 110/111. Fetch always goes to operand. Operand goes to load-acc, write-mem, exec-add or trap for opcode 00, 01, 10 or 11.
- R3: In load-acc, `acc_we`=1 and `acc_sel`=1, and the accumulator takes the data-memory word at the instruction address.
- R4: Add is modulo 256 with no carry. Exec-add goes to write-acc. In write-acc, `acc_we`=1 and `acc_sel`=0, and the accumulator takes the old accumulator plus the memory word.
- R5: In write-mem, `dm_we`=1 and the accumulator value is written to data memory at the instruction address.
- R6: Counted from one fetch to the next, load and store take 3 cycles and add takes 4 cycles.
- R7: The instruction register captures instruction memory at the program counter in fetch. The program counter advances by 1, modulo 64, when load-acc, write-acc or write-mem hands back to fetch, and holds otherwise.
- R8: In trap, `halted`=1. The machine stays in trap and makes no accumulator or memory write until reset. `halted`=0 in every other state.
- R9: A synchronous active-high reset sets the state to fetch and clears the program counter and the accumulator.
- R10: A load-port word is written when `ld_valid` and `ld_ready` are both high. `ld_target`=0 selects instruction memory and 1 selects data memory. `ld_ready` is 0 only in write-mem.
- R11: The outputs depend on the state only. Outside load-acc and write-acc, `acc_we`=0 and the accumulator holds. Outside write-mem, `dm_we`=0. `acc_sel`=1 only in load-acc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load-port word offered |
| ld_ready | output | 1 | Load port can accept a word |
| ld_target | input | 1 | 0 = instruction memory, 1 = data memory |
| ld_addr | input | 6 | Load-port word address |
| ld_data | input | 8 | Load-port word |
| state_o | output | 3 | Current state code |
| acc_we | output | 1 | Accumulator write enable |
| acc_sel | output | 1 | Accumulator source: 1 memory, 0 adder |
| dm_we | output | 1 | Data-memory write by the machine |
| acc_o | output | 8 | Accumulator |
| pc_o | output | 6 | Program counter |
| halted | output | 1 | Machine is in trap |

## Verification
The bench builds the block with its defaults: 8-bit data and 6-bit addresses, which gives two 64-word memories. Runs of a few hundred cycles therefore wrap the program counter past 63, and random 8-bit operands make modulo-256 wrap in add a frequent event. Because the address space is small, random load-port writes often land on words the program is using, and some of them arrive during a store cycle, where the port must stall.

// File: rtl/acc_mc_pkg.sv
package acc_mc_pkg;
  typedef enum logic [2:0] {
    ST_FETCH = 3'b000,
    ST_OPND  = 3'b001,
    ST_WRACC = 3'b010,
    ST_LOAD  = 3'b011,
    ST_EXADD = 3'b100,
    ST_WRDM  = 3'b101,
    ST_TRAP  = 3'b110,
    ST_TRAPX = 3'b111
  } ctrl_state_t;

  localparam logic [1:0] OPC_LOAD  = 2'b00;
  localparam logic [1:0] OPC_STORE = 2'b01;
  localparam logic [1:0] OPC_ADD   = 2'b10;
endpackage

// File: rtl/acc_mc_mem.sv
module acc_mc_mem #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 6,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/acc_mc_ctrl.sv
module acc_mc_ctrl
  import acc_mc_pkg::*;
#(
  parameter int OPC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic [2:0]       state_o,
  output logic             ir_load,
  output logic             sum_en,
  output logic             pc_inc,
  output logic             acc_we,
  output logic             acc_sel,
  output logic             dm_we,
  output logic             halted
);
  ctrl_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_FETCH: st_d = ST_OPND;
      ST_OPND: begin
        if (opcode == OPC_LOAD)       st_d = ST_LOAD;
        else if (opcode == OPC_STORE) st_d = ST_WRDM;
        else if (opcode == OPC_ADD)   st_d = ST_EXADD;
        else                          st_d = ST_TRAP;
      end
      ST_EXADD: st_d = ST_WRACC;
      ST_LOAD, ST_WRACC, ST_WRDM: st_d = ST_FETCH;
      ST_TRAP, ST_TRAPX: st_d = st_q;
      default: st_d = ST_TRAP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_FETCH;
    else     st_q <= st_d;
  end

  assign state_o = st_q;
  assign ir_load = (st_q == ST_FETCH);
  assign sum_en  = (st_q == ST_EXADD);
  assign acc_sel = (st_q == ST_LOAD);
  assign acc_we  = (st_q == ST_LOAD) || (st_q == ST_WRACC);
  assign dm_we   = (st_q == ST_WRDM);
  assign pc_inc  = (st_q == ST_LOAD) || (st_q == ST_WRACC) || (st_q == ST_WRDM);
  assign halted  = (st_q == ST_TRAP) || (st_q == ST_TRAPX);

  assert_fetch_to_operand_R2: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FETCH) |=> (st_q == ST_OPND));
  assert_exadd_to_wracc_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_EXADD) |=> (st_q == ST_WRACC));
  assert_trap_absorbs_R8: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);
  assert_single_writer_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({acc_we, dm_we}));
endmodule

// File: rtl/acc_mc_datapath.sv
module acc_mc_datapath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int OPC_W  = 2,
  localparam int INSTR_W = OPC_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] imem_rdata,
  input  logic [DATA_W-1:0]  dmem_rdata,
  input  logic               ir_load,
  input  logic               sum_en,
  input  logic               pc_inc,
  input  logic               acc_we,
  input  logic               acc_sel,
  output logic [ADDR_W-1:0]  pc,
  output logic [OPC_W-1:0]   opcode,
  output logic [ADDR_W-1:0]  op_addr,
  output logic [DATA_W-1:0]  acc
);
  logic [INSTR_W-1:0] ir_q;
  logic [DATA_W-1:0]  sum_q;
  logic [DATA_W-1:0]  acc_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      ir_q <= '0;
    end else begin
      if (pc_inc)  pc   <= pc + ADDR_W'(1);
      if (ir_load) ir_q <= imem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (sum_en) sum_q <= acc + dmem_rdata;
  end

  assign acc_d = acc_sel ? dmem_rdata : sum_q;

  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (acc_we) acc <= acc_d;
  end

  assign opcode  = ir_q[INSTR_W-1 -: OPC_W];
  assign op_addr = ir_q[ADDR_W-1:0];

  assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
    pc_inc |=> (pc == $past(pc) + ADDR_W'(1)));
  assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !pc_inc |=> $stable(pc));
  assert_acc_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !acc_we |=> $stable(acc));
endmodule

// File: rtl/acc_mc_core.sv
module acc_mc_core
  import acc_mc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int OPC_W  = 2,
  localparam int INSTR_W = OPC_W + ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_valid,
  output logic              ld_ready,
  input  logic              ld_target,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] ld_data,
  output logic [2:0]        state_o,
  output logic              acc_we,
  output logic              acc_sel,
  output logic              dm_we,
  output logic [DATA_W-1:0] acc_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              halted
);
  logic               ir_load, sum_en, pc_inc, ld_fire;
  logic [OPC_W-1:0]   opcode;
  logic [ADDR_W-1:0]  op_addr;
  logic [INSTR_W-1:0] imem_rdata;
  logic [DATA_W-1:0]  dmem_rdata;
  logic               dmem_we;
  logic [ADDR_W-1:0]  dmem_waddr;
  logic [DATA_W-1:0]  dmem_wdata;

  acc_mc_ctrl #(.OPC_W(OPC_W)) ctrl_i (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .ir_load(ir_load), .sum_en(sum_en), .pc_inc(pc_inc),
    .acc_we(acc_we), .acc_sel(acc_sel), .dm_we(dm_we), .halted(halted)
  );

  acc_mc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) dp_i (
    .clk(clk), .rst(rst), .imem_rdata(imem_rdata), .dmem_rdata(dmem_rdata),
    .ir_load(ir_load), .sum_en(sum_en), .pc_inc(pc_inc),
    .acc_we(acc_we), .acc_sel(acc_sel),
    .pc(pc_o), .opcode(opcode), .op_addr(op_addr), .acc(acc_o)
  );

  assign ld_ready = !dm_we;
  assign ld_fire  = ld_valid && ld_ready;

  acc_mc_mem #(.WIDTH(INSTR_W), .ADDR_W(ADDR_W)) imem_i (
    .clk(clk), .we(ld_fire && !ld_target), .waddr(ld_addr),
    .wdata(INSTR_W'(ld_data)), .raddr(pc_o), .rdata(imem_rdata)
  );

  assign dmem_we    = dm_we || (ld_fire && ld_target);
  assign dmem_waddr = dm_we ? op_addr : ld_addr;
  assign dmem_wdata = dm_we ? acc_o : ld_data;

  acc_mc_mem #(.WIDTH(DATA_W), .ADDR_W(ADDR_W)) dmem_i (
    .clk(clk), .we(dmem_we), .waddr(dmem_waddr),
    .wdata(dmem_wdata), .raddr(op_addr), .rdata(dmem_rdata)
  );

  assert_trap_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!acc_we && !dm_we && $stable(acc_o)));
  assert_store_needs_stall_R10: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'b101) |-> !(ld_valid && ld_ready));
endmodule

// File: tb/acc_mc_core_tb_top.sv
module acc_mc_core_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_valid = 1'b0, ld_target = 1'b0;
  logic [5:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic ld_ready, acc_we, acc_sel, dm_we, halted;
  logic [2:0] state_o;
  logic [7:0] acc_o;
  logic [5:0] pc_o;

  int n_checks = 0, n_errors = 0;
  bit finished = 1'b0;

  logic [7:0] m_imem [64];
  logic [7:0] m_dmem [64];
  logic [2:0] m_st;
  logic [5:0] m_pc;
  logic [7:0] m_acc, m_ir, m_sum;
  int cyc_since_fetch;
  logic [1:0] last_opc;

  always #5 clk = ~clk;

  acc_mc_core dut_i (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_target(ld_target), .ld_addr(ld_addr), .ld_data(ld_data),
    .state_o(state_o), .acc_we(acc_we), .acc_sel(acc_sel), .dm_we(dm_we),
    .acc_o(acc_o), .pc_o(pc_o), .halted(halted)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] next_st(input logic [2:0] s, input logic [1:0] opc);
    case (s)
      3'b000: return 3'b001;
      3'b001: return (opc == 2'b00) ? 3'b011 : (opc == 2'b01) ? 3'b101 :
                     (opc == 2'b10) ? 3'b100 : 3'b110;
      3'b100: return 3'b010;
      3'b011, 3'b010, 3'b101: return 3'b000;
      default: return s;
    endcase
  endfunction

  function automatic int instr_len(input logic [1:0] opc);
    return (opc == 2'b10) ? 4 : 3;
  endfunction

  // Compare every output against the model state (R2, R3, R4, R5, R7, R8, R10, R11)
  task automatic compare_outputs();
    chk("R2 state", state_o, m_st);
    chk("R3 acc_sel", acc_sel, m_st == 3'b011);
    chk("R11 acc_we", acc_we, (m_st == 3'b011) || (m_st == 3'b010));
    chk("R5 dm_we", dm_we, m_st == 3'b101);
    chk("R10 ld_ready", ld_ready, m_st != 3'b101);
    chk("R8 halted", halted, m_st[2:1] == 2'b11);
    chk("R4 acc", acc_o, m_acc);
    chk("R7 pc", pc_o, m_pc);
    // R6: cycles between fetches
    if (state_o == 3'b000) begin
      if (cyc_since_fetch > 0) chk("R6 cycle count", cyc_since_fetch, instr_len(last_opc));
      cyc_since_fetch = 1;
      last_opc = m_imem[m_pc][7:6];
    end else if (cyc_since_fetch > 0) cyc_since_fetch++;
  endtask

  // Model of one rising edge with rst low, using the inputs now driven
  task automatic model_step();
    logic [2:0] s = m_st;
    logic [5:0] a = m_ir[5:0];
    logic [7:0] rd = m_dmem[a];
    logic fire = ld_valid && (s != 3'b101);
    if (s == 3'b000) m_ir = m_imem[m_pc];
    if (s == 3'b011) m_acc = rd;
    if (s == 3'b100) m_sum = m_acc + rd;
    if (s == 3'b010) m_acc = m_sum;
    if (s == 3'b101) m_dmem[a] = m_acc;
    if (s == 3'b011 || s == 3'b010 || s == 3'b101) m_pc = m_pc + 6'd1;
    if (fire) begin
      if (ld_target) m_dmem[ld_addr] = ld_data;
      else           m_imem[ld_addr] = ld_data;
    end
    m_st = next_st(s, m_ir[7:6]);
  endtask

  // Reset, check reset state (R9), then fill memories through the port (R10)
  task automatic reset_and_load(input int mode);
    @(negedge clk);
    rst = 1'b1; ld_valid = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R9 reset state", state_o, 0);
    chk("R9 reset pc", pc_o, 0);
    chk("R9 reset acc", acc_o, 0);
    chk("R9 reset halted", halted, 0);
    m_st = 3'b000; m_pc = '0; m_acc = '0; m_ir = '0;
    cyc_since_fetch = 0;
    for (int k = 0; k < 128; k++) begin
      logic [7:0] w;
      logic [31:0] r = $urandom;
      if (k < 64) begin
        if (mode == 0) w = 8'hC0;
        else if (mode == 1) w = {2'(r % 3), r[13:8]};
        else w = {((r % 24) == 0) ? 2'b11 : 2'(r % 3), r[13:8]};
      end else w = r[23:16];
      ld_valid = 1'b1; ld_target = (k >= 64); ld_addr = 6'(k); ld_data = w;
      if (k < 64) m_imem[k] = w; else m_dmem[k - 64] = w;
      @(negedge clk);
      chk("R10 ready in reset", ld_ready, 1);
    end
    ld_valid = 1'b0;
  endtask

  task automatic poke(input bit tgt, input int adr, input logic [7:0] d);
    ld_valid = 1'b1; ld_target = tgt; ld_addr = 6'(adr); ld_data = d;
    if (tgt) m_dmem[adr] = d; else m_imem[adr] = d;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run(input int n, input bit rand_ld);
    rst = 1'b0;
    model_step();
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      compare_outputs();
      ld_valid = 1'b0;
      if (rand_ld && ($urandom % 4 == 0)) begin
        ld_valid = 1'b1; ld_target = $urandom % 2;
        ld_addr = 6'($urandom); ld_data = 8'($urandom);
      end
      model_step();
    end
    ld_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    // Directed program: load, add with wrap, store, add, store, load, illegal (R1, R4, R5, R8)
    reset_and_load(0);
    poke(1'b0, 0, 8'h05); poke(1'b0, 1, 8'h86); poke(1'b0, 2, 8'h47);
    poke(1'b0, 3, 8'h87); poke(1'b0, 4, 8'h48); poke(1'b0, 5, 8'h08);
    poke(1'b1, 5, 8'd200); poke(1'b1, 6, 8'd100);
    run(40, 1'b0);
    chk("R4 add wrap result", acc_o, 88);
    chk("R8 trapped", halted, 1);
    chk("R8 pc frozen at illegal", pc_o, 6);
    chk("R5 stored word", m_dmem[7], 44);
    // Port writes while trapped leave the machine parked (R8)
    run(20, 1'b1);
    chk("R8 still trapped", halted, 1);
    // Random programs: no illegal opcodes, then a few illegal ones (R1-related mix)
    reset_and_load(1);
    chk("R9 leaves trap", halted, 0);
    run(300, 1'b1);
    reset_and_load(2);
    run(300, 1'b1);
    reset_and_load(2);
    run(300, 1'b0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule